// File: doc/BRIEF.md
# DRAM Refresh Scheduler (CAS-before-RAS)

This block keeps a dynamic memory alive without any row address. It counts clock cycles between refresh slots, keeps a tally of slots that have not yet been served, and, when it has work, asks the memory controller for the shared strobe lines. Once granted it lowers the column strobe first and the row strobe one cycle later. The write strobe stays at the read level throughout. The memory's own internal counter then selects the row. The part needs 4096 such cycles per 64 ms, so the default spacing is 1560 cycles of a 100 MHz clock.

After reset the scheduler first runs a start-up burst of eight refresh cycles back to back under a single request. It then reports that the memory is ready for use. In normal operation a refresh slot that falls while the controller keeps the bus busy is not lost. It is counted, and all counted slots are issued back to back at the next grant. The count saturates at eight, and a slot that arrives at saturation raises a sticky overflow flag. From four pending slots on, an urgency output tells the controller to serve refresh before new host requests.

Each refresh cycle lasts 12 clocks: 1 clock of column strobe lead, 6 clocks of row strobe low with the column strobe held low for the first of them, and 5 clocks of precharge. That is 120 ns at 100 MHz.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, req and strobeOe are low, rasN, casN and weN are high, and overflow and initDone are low.
- R2: After reset exactly 8 refresh cycles run back to back under one continuous request (req falls once). initDone goes high when the eighth cycle ends and stays high.
- R3: In every refresh cycle casN goes low exactly 1 cycle before rasN falls and stays low for exactly 1 cycle after rasN falls.
- R4: rasN stays low for exactly 6 cycles. At least 5 high (precharge) cycles separate a rise of rasN from the next fall of casN. weN is high in every cycle.
- R5: strobeOe is high, or rasN or casN is low, only while gnt is high. Once raised, req stays high until gnt is seen.
- R6: Refresh slots occur every N cycles, where N is the interval register (reset value 1560). A write on cfgWr loads cfgInterval and restarts the timer, so the next slot comes N cycles after the write. A value of 0 acts as 1.
- R7: Slots that arrive while gnt is withheld are counted. On the next grant they are all issued back to back with req held high throughout.
- R8: urgent is high exactly when 4 or more slots are pending.
- R9: The pending count saturates at 8. A slot arriving while 8 are pending is dropped and sets overflow, which stays high until reset.
- R10: When no work remains, req falls on the clock edge that ends the fifth precharge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Loads cfgInterval and restarts the timer |
| cfgInterval | input | 16 | Refresh spacing in clock cycles |
| gnt | input | 1 | Strobe bus grant from the memory controller |
| req | output | 1 | Strobe bus request |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write strobe, held at read level (high) |
| strobeOe | output | 1 | The scheduler is driving the strobe lines |
| urgent | output | 1 | Four or more refreshes pending |
| overflow | output | 1 | Sticky: a refresh slot was dropped at saturation |
| initDone | output | 1 | Start-up burst finished |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- the column strobe leads each fall of the row strobe;
- strobes are driven only under grant;
- a request is held until it is granted;
- the request is released only from precharge;
- the pending count moves by at most one per cycle;
- overflow and initDone are sticky;
- the timer reloads after each slot.

Some properties depend on history and counts, and only the bench scenarios can show them:
- the exact length of the start-up burst;
- the spacing at the default and at reprogrammed intervals;
- the number of refreshes drained after a long withheld grant;
- the urgency threshold;
- saturation at eight.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CSR,
    ST_RAS,
    ST_PRE
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCsr;
    logic loadRas;
    logic loadPre;
    logic cycleDone;
  } seqCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic phaseLast;
    logic needNow;
    logic needAfter;
  } seqStat_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int IV_W         = 16,
  parameter int DEF_INTERVAL = 1560,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_PEND     = 8,
  parameter int URGENT_TH    = 4,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 6,
  parameter int PRE_CYC      = 5,
  parameter int PH_W         = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWr,
  input  logic [IV_W-1:0] cfgInterval,
  input  seqCmd_t         cmd,
  output logic [PH_W-1:0] phaseCnt,
  output seqStat_t        stat,
  output logic            urgent,
  output logic            overflow,
  output logic            initDone
);

  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int PD_W   = $clog2(MAX_PEND + 1);

  function automatic logic [IV_W-1:0] reloadOf(input logic [IV_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  // ---------------- interval timer ----------------
  logic [IV_W-1:0] ivReg, tmrCnt;
  logic            tick;

  assign tick = (tmrCnt == '0) && !cfgWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivReg  <= IV_W'(DEF_INTERVAL);
      tmrCnt <= IV_W'(DEF_INTERVAL - 1);
    end else if (cfgWr) begin
      ivReg  <= cfgInterval;
      tmrCnt <= reloadOf(cfgInterval);
    end else if (tmrCnt == '0) begin
      tmrCnt <= reloadOf(ivReg);
    end else begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  a_r6_tick_reload: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> tmrCnt == reloadOf($past(ivReg)));

  // ---------------- start-up and pending counters ----------------
  logic [INIT_W-1:0] initLeft;
  logic [PD_W-1:0]   pend;
  logic              decPend;

  assign decPend = cmd.cycleDone && (initLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initLeft <= INIT_W'(INIT_CYCLES);
    end else if (cmd.cycleDone && (initLeft != '0)) begin
      initLeft <= initLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      overflow <= 1'b0;
    end else begin
      if (tick && !decPend) begin
        if (pend == PD_W'(MAX_PEND)) overflow <= 1'b1;
        else                         pend     <= pend + 1'b1;
      end else if (decPend && !tick && (pend != '0)) begin
        pend <= pend - 1'b1;
      end
    end
  end

  assign initDone = (initLeft == '0);
  assign urgent   = (pend >= PD_W'(URGENT_TH));

  always_comb begin
    stat.needNow   = (initLeft != '0) || (pend != '0);
    stat.needAfter = (initLeft > INIT_W'(1))
                  || ((initLeft == INIT_W'(1)) && ((pend != '0) || tick))
                  || ((initLeft == '0) && ((pend > PD_W'(1)) || ((pend == PD_W'(1)) && tick)));
    stat.phaseLast = (phaseCnt == '0);
  end

  a_r7_pend_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pend) |-> (pend == $past(pend) + 1'b1) || (pend == $past(pend) - 1'b1));
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  a_r9_ovf_at_sat: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(pend) == PD_W'(MAX_PEND));
  a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // ---------------- strobe phase counter ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= '0;
    else if (cmd.loadCsr)   phaseCnt <= PH_W'(CSR_CYC - 1);
    else if (cmd.loadRas)   phaseCnt <= PH_W'(RAS_CYC - 1);
    else if (cmd.loadPre)   phaseCnt <= PH_W'(PRE_CYC - 1);
    else if (phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
  end

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int RAS_CYC = 6,
  parameter int CHR_CYC = 1,
  parameter int PH_W    = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            gnt,
  input  logic [PH_W-1:0] phaseCnt,
  input  seqStat_t        stat,
  output seqCmd_t         cmd,
  output logic            req,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic            strobeOe
);

  localparam logic [PH_W-1:0] CAS_HOLD_ABOVE = PH_W'(RAS_CYC - 1 - CHR_CYC);

  seqState_e state, nxt;

  always_comb begin
    nxt = state;
    cmd = '0;
    unique case (state)
      ST_IDLE: if (stat.needNow) nxt = ST_WAIT;
      ST_WAIT: if (gnt) begin
        nxt = ST_CSR;
        cmd.loadCsr = 1'b1;
      end
      ST_CSR: if (stat.phaseLast) begin
        nxt = ST_RAS;
        cmd.loadRas = 1'b1;
      end
      ST_RAS: if (stat.phaseLast) begin
        nxt = ST_PRE;
        cmd.loadPre = 1'b1;
      end
      ST_PRE: if (stat.phaseLast) begin
        cmd.cycleDone = 1'b1;
        if (stat.needAfter) begin
          nxt = ST_CSR;
          cmd.loadCsr = 1'b1;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    req      = (state != ST_IDLE);
    strobeOe = (state == ST_CSR) || (state == ST_RAS) || (state == ST_PRE);
    rasN     = !(state == ST_RAS);
    casN     = !((state == ST_CSR) || ((state == ST_RAS) && (phaseCnt > CAS_HOLD_ABOVE)));
    weN      = 1'b1;
  end

  a_r5_strobe_gnt: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOe || !rasN || !casN) |-> gnt);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (req && !gnt) |=> req);
  a_r3_cas_lead: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !casN && $past(!casN));
  a_r10_req_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(req) |-> $past(state == ST_PRE) && rasN && casN);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int IV_W         = 16,
  parameter int DEF_INTERVAL = 1560,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_PEND     = 8,
  parameter int URGENT_TH    = 4,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 6,
  parameter int PRE_CYC      = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWr,
  input  logic [IV_W-1:0] cfgInterval,
  input  logic            gnt,
  output logic            req,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic            strobeOe,
  output logic            urgent,
  output logic            overflow,
  output logic            initDone
);

  localparam int MAXC  = (RAS_CYC > PRE_CYC) ? ((RAS_CYC > CSR_CYC) ? RAS_CYC : CSR_CYC)
                                             : ((PRE_CYC > CSR_CYC) ? PRE_CYC : CSR_CYC);
  localparam int PH_W  = $clog2(MAXC + 1);

  seqCmd_t         cmd;
  seqStat_t        stat;
  logic [PH_W-1:0] phaseCnt;

  refsched_ctrl #(
    .RAS_CYC(RAS_CYC), .CHR_CYC(CHR_CYC), .PH_W(PH_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .gnt(gnt), .phaseCnt(phaseCnt), .stat(stat),
    .cmd(cmd), .req(req), .rasN(rasN), .casN(casN), .weN(weN), .strobeOe(strobeOe)
  );

  refsched_dp #(
    .IV_W(IV_W), .DEF_INTERVAL(DEF_INTERVAL), .INIT_CYCLES(INIT_CYCLES),
    .MAX_PEND(MAX_PEND), .URGENT_TH(URGENT_TH), .CSR_CYC(CSR_CYC),
    .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC), .PH_W(PH_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgInterval(cfgInterval), .cmd(cmd),
    .phaseCnt(phaseCnt), .stat(stat), .urgent(urgent), .overflow(overflow),
    .initDone(initDone)
  );

endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [15:0] cfgInterval = '0;
  logic        gnt = 1'b0;
  logic        req, rasN, casN, weN, strobeOe, urgent, overflow, initDone;

  always #5 clk = ~clk;

  refresh_sched dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgInterval(cfgInterval), .gnt(gnt),
    .req(req), .rasN(rasN), .casN(casN), .weN(weN), .strobeOe(strobeOe),
    .urgent(urgent), .overflow(overflow), .initDone(initDone)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit allowGnt = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- monitor: samples 2 ns after each rising edge ----------------
  int rasFalls = 0, reqFalls = 0, lastSpacing = 0, lastFall = 0, cyc = 0;
  int casLead = 0, rasLow = 0, chrCnt = 0, highRun = 100, sinceRise = 0;
  int vioCsr = 0, vioChr = 0, vioRas = 0, vioPre = 0, vioWe = 0;
  int vioGnt = 0, vioReq = 0, vioRel = 0;
  logic prevRas = 1'b1, prevCas = 1'b1, prevReq = 1'b0, prevGnt = 1'b0;

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      cyc++;
      if (!rasN && prevRas) begin
        if (casLead != 1) vioCsr++;
        rasFalls++;
        lastSpacing = cyc - lastFall;
        lastFall = cyc;
        rasLow = 1;
        chrCnt = casN ? 0 : 1;
      end else if (!rasN) begin
        rasLow++;
        if (!casN) chrCnt++;
      end
      if (rasN && !prevRas) begin
        if (rasLow != 6) vioRas++;
        if (chrCnt != 1) vioChr++;
      end
      if (!casN && prevCas && rasN && highRun < 5) vioPre++;
      if (rasN && casN) highRun++;
      else if (!rasN) highRun = 0;
      if (rasN && !casN) casLead++;
      else casLead = 0;
      if (!rasN) sinceRise = 0;
      else if (casN && req) sinceRise++;
      if (prevReq && !req) begin
        reqFalls++;
        if (sinceRise != 5) vioRel++;
      end
      if (prevReq && !prevGnt && !req) vioReq++;
      if (!weN) vioWe++;
      if ((strobeOe || !rasN || !casN) && !gnt) vioGnt++;
      prevRas = rasN; prevCas = casN; prevReq = req; prevGnt = gnt;
      gnt <= req && allowGnt;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeIv(input int v);
    cfgInterval = 16'(v);
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic waitReqLow(input int limit);
    for (int i = 0; i < limit && req; i++) @(negedge clk);
  endtask

  localparam int NVEC = 4;
  localparam int VEC_IV [NVEC] = '{40, 100, 300, 25};
  localparam int VEC_N  [NVEC] = '{4, 3, 2, 5};

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int f0, r0;
    // R1: reset state
    waitCyc(2);
    chk(!req && !strobeOe, "R1 req/oe", {req, strobeOe}, 0);
    chk(rasN && casN && weN, "R1 strobes", {rasN, casN, weN}, 7);
    chk(!overflow && !initDone, "R1 flags", {overflow, initDone}, 0);
    rstN = 1'b1;

    // R2: start-up burst
    for (int i = 0; i < 400 && !initDone; i++) @(negedge clk);
    waitCyc(3);
    chk(rasFalls == 8, "R2 burst count", rasFalls, 8);
    chk(reqFalls == 1, "R2 single request", reqFalls, 1);
    chk(initDone, "R2 initDone", initDone, 1);

    // R6: default interval
    for (int i = 0; i < 4000 && rasFalls < 10; i++) @(negedge clk);
    chk(lastSpacing == 1560, "R6 default spacing", lastSpacing, 1560);

    // R6: vector table of programmed intervals
    for (int v = 0; v < NVEC; v++) begin
      waitReqLow(100);
      f0 = rasFalls;
      writeIv(VEC_IV[v]);
      waitCyc(VEC_N[v] * VEC_IV[v] + 16);
      chk(rasFalls - f0 == VEC_N[v], "R6 count in window", rasFalls - f0, VEC_N[v]);
      chk(lastSpacing == VEC_IV[v], "R6 spacing", lastSpacing, VEC_IV[v]);
    end

    // R7/R8: postponed refreshes
    waitReqLow(100);
    allowGnt = 1'b0;
    writeIv(20);
    waitCyc(69);
    chk(urgent == 1'b0, "R8 three pending", urgent, 0);
    chk(req && rasN && !strobeOe, "R5 waits for grant", {req, rasN, strobeOe}, 6);
    waitCyc(20);
    chk(urgent == 1'b1, "R8 four pending", urgent, 1);
    waitCyc(15);
    f0 = rasFalls; r0 = reqFalls;
    writeIv(3000);
    allowGnt = 1'b1;
    waitCyc(3);
    waitReqLow(300);
    chk(rasFalls - f0 == 5, "R7 drained count", rasFalls - f0, 5);
    chk(reqFalls - r0 == 1, "R7 back to back", reqFalls - r0, 1);
    chk(!urgent && !overflow, "R8 R9 after drain", {urgent, overflow}, 0);

    // R9: saturation and sticky overflow
    allowGnt = 1'b0;
    writeIv(20);
    waitCyc(169);
    chk(!overflow && urgent, "R9 eight pending", {overflow, urgent}, 1);
    waitCyc(20);
    chk(overflow, "R9 overflow set", overflow, 1);
    waitCyc(5);
    f0 = rasFalls;
    writeIv(3000);
    allowGnt = 1'b1;
    waitCyc(3);
    waitReqLow(300);
    chk(rasFalls - f0 == 8, "R9 saturated drain", rasFalls - f0, 8);
    chk(overflow, "R9 overflow sticky", overflow, 1);

    // per-cycle rules seen by the monitor
    chk(vioCsr == 0, "R3 cas lead", vioCsr, 0);
    chk(vioChr == 0, "R3 cas hold", vioChr, 0);
    chk(vioRas == 0, "R4 ras width", vioRas, 0);
    chk(vioPre == 0, "R4 precharge", vioPre, 0);
    chk(vioWe == 0, "R4 we high", vioWe, 0);
    chk(vioGnt == 0, "R5 strobes under grant", vioGnt, 0);
    chk(vioReq == 0, "R5 req held", vioReq, 0);
    chk(vioRel == 0, "R10 req release", vioRel, 0);
    summary();
  end

endmodule